// File: doc/BRIEF.md
# Fixed-Latency Integer Divider

A 32-bit sequential divider for an integer execution stage. A one-cycle start request captures a dividend (the destination's current value), a divisor and a signed/unsigned select. Illegal operand pairs are caught in the capture cycle. The quotient is then built on operand magnitudes by restoring shift-and-subtract, two quotient bits per clock. After the result is ready, the block pads out to a worst-case latency that depends only on the mode. Issue logic can therefore schedule the write-back slot without watching the operands.

At completion the block raises a one-cycle done pulse. A legal division also writes the quotient to the destination register held inside the block, and clears the overflow flag. An illegal division sets the overflow flag, suppresses the write and leaves the destination untouched.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (signed_i = 0) with a nonzero divisor, the quotient is floor(dividend / divisor) on 32-bit unsigned values. For example, 0x80000000 / 0xFFFFFFFF gives 0.
- R2: In signed mode (signed_i = 1) the quotient is the two's-complement quotient truncated toward zero. For example, -7 / 2 gives 0xFFFFFFFD.
- R3: ovf_o is set at completion for two cases: a zero divisor in either mode, and, in signed mode only, a dividend of 0x80000000 with a divisor of 0xFFFFFFFF. A legal division clears ovf_o. ovf_o keeps its value between completions.
- R4: When ovf_o is set at completion, wr_en_o stays low and quotient_o keeps the value it had before the operation.
- R5: done_o is high for exactly one cycle. It rises on the 22nd rising edge after the edge that accepted a signed request, and on the 20th after an unsigned one.
- R6: wr_en_o is high only in the done cycle of a legal division, and quotient_o changes only on that same edge.
- R7: A start request that arrives while busy_o is high is ignored. It produces no extra completion and does not change the result of the operation in flight.
- R8: While rst_ni is low, busy_o, done_o, wr_en_o and ovf_o are low and quotient_o is zero.
- R9: busy_o is high from the accepting edge until the completion edge, and is low during the done cycle. A start request presented in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Division request, sampled when busy_o is low |
| signed_i | input | 1 | 1: two's-complement division, 0: unsigned |
| dividend_i | input | 32 | Dividend (destination operand) |
| divisor_i | input | 32 | Divisor (source operand) |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Destination register value |
| wr_en_o | output | 1 | Destination written this cycle |
| ovf_o | output | 1 | Overflow flag of the last completed division |

## Verification
A corrupted latency counter appears at once as a done pulse on the wrong cycle. The per-clock comparison catches it on the first operation. A fault in the shift-subtract slices or in the remainder register stays inside the block until completion. It then shows as a wrong quotient in the done cycle, 20 or 22 cycles after the start. A wrong overflow decision shows on the same edge in two places: the flag has the wrong value, and the quotient either changes when it should hold or holds when it should change. Sign handling is exercised with all four sign combinations, so a fault in the negation path shows up on the first mixed-sign vector.

// File: rtl/div_pkg.sv
`timescale 1ns/100ps
package div_pkg;
  localparam int unsigned DIV_W     = 32;
  localparam int unsigned DIV_BPC   = 2;   // quotient bits per clock
  localparam int unsigned DIV_LAT_S = 22;
  localparam int unsigned DIV_LAT_U = 20;
endpackage

// File: rtl/div_precheck.sv
`timescale 1ns/100ps
module div_precheck #(
  parameter int unsigned W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic dvd_neg, dvs_neg;

  assign dvd_neg   = signed_i & dividend_i[W-1];
  assign dvs_neg   = signed_i & divisor_i[W-1];
  assign dvd_mag_o = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign dvs_mag_o = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;
  assign neg_o     = dvd_neg ^ dvs_neg;

  always_comb begin
    ovf_o = (divisor_i == '0);
    if (signed_i && dividend_i == MOST_NEG && (&divisor_i)) ovf_o = 1'b1;
  end
endmodule

// File: rtl/div_step.sv
`timescale 1ns/100ps
module div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   rem_sh;
  logic [W+1:0] diff;

  assign rem_sh = {rem_i, quo_i[W-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, dvs_i};

  always_comb begin
    if (!diff[W+1]) begin
      rem_o = diff[W-1:0];
      quo_o = {quo_i[W-2:0], 1'b1};
    end else begin
      rem_o = rem_sh[W-1:0];
      quo_o = {quo_i[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/div_ctrl.sv
`timescale 1ns/100ps
module div_ctrl #(
  parameter int unsigned ITER  = 16,
  parameter int unsigned LAT_S = 22,
  parameter int unsigned LAT_U = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic signed_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic finish_o
);
  localparam int unsigned LAT_MAX = (LAT_S > LAT_U) ? LAT_S : LAT_U;
  localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);
  localparam int unsigned STP_W   = $clog2(ITER + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [STP_W-1:0] stp_q;

  assign busy_o   = busy_q;
  assign load_o   = start_i & ~busy_q;
  assign step_o   = busy_q & (stp_q < STP_W'(ITER));
  assign finish_o = busy_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      stp_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= signed_i ? CNT_W'(LAT_S - 1) : CNT_W'(LAT_U - 1);
      stp_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (step_o) stp_q <= stp_q + 1'b1;
    end
  end
endmodule

// File: rtl/int_divider.sv
`timescale 1ns/100ps
module int_divider
  import div_pkg::*;
#(
  parameter int unsigned W            = DIV_W,
  parameter int unsigned BPC          = DIV_BPC,
  parameter int unsigned LAT_SIGNED   = DIV_LAT_S,
  parameter int unsigned LAT_UNSIGNED = DIV_LAT_U
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic         wr_en_o,
  output logic         ovf_o
);
  localparam int unsigned ITER = W / BPC;

  logic [W-1:0] dvd_mag, dvs_mag;
  logic         pre_neg, pre_ovf;
  logic         load, step, finish;

  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic         neg_q, ovf_pend_q;
  logic         done_q, wr_q, ovf_q;
  logic [W-1:0] res_q;

  logic [W-1:0] rem_c [BPC+1];
  logic [W-1:0] quo_c [BPC+1];

  div_precheck #(.W(W)) u_pre (
    .signed_i  (signed_i),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_o     (pre_neg),
    .ovf_o     (pre_ovf)
  );

  div_ctrl #(.ITER(ITER), .LAT_S(LAT_SIGNED), .LAT_U(LAT_UNSIGNED)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .signed_i(signed_i),
    .busy_o  (busy_o),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish)
  );

  assign rem_c[0] = rem_q;
  assign quo_c[0] = quo_q;

  for (genvar g = 0; g < BPC; g++) begin : g_slice
    div_step #(.W(W)) u_step (
      .rem_i(rem_c[g]),
      .quo_i(quo_c[g]),
      .dvs_i(dvs_q),
      .rem_o(rem_c[g+1]),
      .quo_o(quo_c[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      neg_q      <= 1'b0;
      ovf_pend_q <= 1'b0;
    end else if (load) begin
      rem_q      <= '0;
      quo_q      <= dvd_mag;
      dvs_q      <= dvs_mag;
      neg_q      <= pre_neg;
      ovf_pend_q <= pre_ovf;
    end else if (step) begin
      rem_q <= rem_c[BPC];
      quo_q <= quo_c[BPC];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ovf_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= finish;
      wr_q   <= finish & ~ovf_pend_q;
      if (finish) begin
        ovf_q <= ovf_pend_q;
        if (!ovf_pend_q) res_q <= neg_q ? (~quo_q + 1'b1) : quo_q;
      end
    end
  end

  assign done_o     = done_q;
  assign wr_en_o    = wr_q;
  assign ovf_o      = ovf_q;
  assign quotient_o = res_q;
endmodule

// File: rtl/div_checker.sv
`timescale 1ns/100ps
module div_checker
  import div_pkg::*;
#(
  parameter int unsigned W     = DIV_W,
  parameter int unsigned LAT_S = DIV_LAT_S,
  parameter int unsigned LAT_U = DIV_LAT_U
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic         wr_en_o,
  input logic         ovf_o
);
  localparam int unsigned LAT_MAX = (LAT_S > LAT_U) ? LAT_S : LAT_U;
  localparam int unsigned CW      = $clog2(LAT_MAX + 2);

  logic          act_q, sgn_q, xovf_q;
  logic [CW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sgn_q  <= 1'b0;
      xovf_q <= 1'b0;
      age_q  <= '0;
    end else if (start_i && !busy_o) begin
      act_q  <= 1'b1;
      sgn_q  <= signed_i;
      age_q  <= '0;
      xovf_q <= (divisor_i == '0) ||
                (signed_i && dividend_i == {1'b1, {(W-1){1'b0}}} && divisor_i == '1);
    end else if (act_q) begin
      if (done_o) act_q <= 1'b0;
      else        age_q <= age_q + 1'b1;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> act_q && (age_q == (sgn_q ? CW'(LAT_S) : CW'(LAT_U)))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_OVF_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ovf_o == xovf_q)); // R3
  AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_en_o == !ovf_o)); // R4
  AST_WR_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o); // R6
  AST_DEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable(quotient_o)); // R4
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ovf_o)); // R3
  AST_BUSY_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R9
endmodule

bind int_divider div_checker u_div_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .dividend_i(dividend_i),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .quotient_o(quotient_o),
  .wr_en_o   (wr_en_o),
  .ovf_o     (ovf_o)
);

// File: tb/int_divider_bench.sv
`timescale 1ns/100ps
module int_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        busy, done, wr, ovf;
  logic [31:0] q;

  int    n_chk = 0;
  int    n_fail = 0;
  string ctx = "R8 reset";

  // reference model state
  bit          m_busy = 1'b0;
  int          m_cnt = 0;
  int          m_lat = 0;
  bit          m_ovf_p = 1'b0;
  logic [31:0] m_res = '0;
  logic        e_done = 1'b0;
  logic        e_wr = 1'b0;
  logic        e_ovf = 1'b0;
  logic [31:0] e_q = '0;

  int_divider u_int_divider (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(a), .divisor_i(b), .busy_o(busy), .done_o(done),
    .quotient_o(q), .wr_en_o(wr), .ovf_o(ovf)
  );

  always #2.5 clk = ~clk;

  function automatic logic [32:0] ref_div(bit s, logic [31:0] x, logic [31:0] y);
    longint sx, sy;
    if (y == 0) return {1'b1, 32'h0};
    if (s) begin
      if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return {1'b1, 32'h0};
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      return {1'b0, 32'(sx / sy)};
    end
    return {1'b0, x / y};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_cnt <= 0; e_done <= 0; e_wr <= 0; e_ovf <= 0; e_q <= '0;
    end else begin
      e_done <= 0;
      e_wr   <= 0;
      if (m_busy) begin
        if (m_cnt + 1 == m_lat) begin
          m_busy <= 0;
          e_done <= 1;
          e_wr   <= !m_ovf_p;
          e_ovf  <= m_ovf_p;
          if (!m_ovf_p) e_q <= m_res;
        end else m_cnt <= m_cnt + 1;
      end else if (start) begin
        logic [32:0] r;
        r = ref_div(sgn, a, b);
        m_busy  <= 1;
        m_cnt   <= 0;
        m_lat   <= sgn ? 22 : 20;
        m_ovf_p <= r[32];
        m_res   <= r[31:0];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R5 done_o", 32'(done), 32'(e_done));
    check("R6 wr_en_o", 32'(wr), 32'(e_wr));
    check("R3 ovf_o", 32'(ovf), 32'(e_ovf));
    check("R1/R2 quotient_o", q, e_q);
    check("R9 busy_o", 32'(busy), 32'(m_busy));
  end

  task automatic run(bit s, logic [31:0] x, logic [31:0] y, string c);
    ctx = c;
    @(negedge clk);
    sgn = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset quotient", q, 32'h0);
    check("R8 reset flags", {29'h0, busy, done, ovf}, 32'h0);
    rst_n = 1'b1;

    run(0, 32'd100, 32'd7, "R1 unsigned basic");
    check("R1 100/7", q, 32'd14);
    run(0, 32'hFFFF_FFFF, 32'd1, "R1 unsigned max");
    run(0, 32'h8000_0000, 32'hFFFF_FFFF, "R1 R3 unsigned no ovf");
    check("R1 0x80000000/0xFFFFFFFF", q, 32'h0);
    check("R3 unsigned min/-1 legal", 32'(ovf), 32'h0);
    run(1, 32'hFFFF_FFF9, 32'd2, "R2 neg/pos");
    check("R2 -7/2", q, 32'hFFFF_FFFD);
    run(1, 32'd7, 32'hFFFF_FFFE, "R2 pos/neg");
    run(1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R2 neg/neg");
    check("R2 -7/-2", q, 32'd3);
    run(1, 32'h8000_0000, 32'hFFFF_FFFF, "R3 R4 signed min/-1");
    check("R3 signed min/-1 ovf", 32'(ovf), 32'h1);
    check("R4 dest held after ovf", q, 32'd3);
    run(1, 32'd55, 32'd0, "R3 R4 signed div0");
    check("R4 dest held after div0", q, 32'd3);
    run(0, 32'd55, 32'd0, "R3 unsigned div0");
    check("R3 unsigned div0 ovf", 32'(ovf), 32'h1);
    run(1, 32'h8000_0000, 32'd1, "R2 signed min/1");
    check("R3 legal clears ovf", 32'(ovf), 32'h0);

    // R7: second request while busy must be dropped
    ctx = "R7 start while busy";
    @(negedge clk);
    sgn = 0; a = 32'd1000; b = 32'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    sgn = 1; a = 32'd9; b = 32'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (24) @(negedge clk);
    check("R7 first result kept", q, 32'd100);

    // R9: new request in the done cycle
    ctx = "R9 back to back";
    @(negedge clk);
    sgn = 1; a = 32'd81; b = 32'hFFFF_FFF7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 30 && !done; i++) @(negedge clk);
    sgn = 0; a = 32'd81; b = 32'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 busy after done-cycle start", 32'(busy), 32'h1);
    repeat (24) @(negedge clk);
    check("R9 second result", q, 32'd20);

    for (int i = 0; i < 12; i++) begin
      seed = nxt(seed);
      a = seed;
      seed = nxt(seed);
      run(i[0], a, seed >> (i % 31), "R1 R2 sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog [%s] actual=hung expected=finished", ctx);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule